// File: doc/BRIEF.md
# Line-Energy Sleep Controller

This block decides when a PHY may drop into a low-power state and when it must come back. While the saving feature is switched on and the line stays silent for a set number of timebase ticks, the controller asserts a power-down request. While asleep it periodically opens a short listening window, with power-down released, so that the line can be checked for link pulses. If the line shows activity inside a window, the controller returns to full power and emits a one-cycle request to restart link negotiation. If the window closes with the line still silent, it goes back to sleep.

Timing is expressed in ticks of an external timebase strobe. The silence time, the sleep interval and the listening-window length are parameters. Clearing the enable input at any moment returns the block to full power at once, without a negotiation request. All outputs are registered, so each one changes on the clock edge after the inputs that cause it.

Top module: `energy_sleep_ctrl`

## Requirements
- R1: When `saver_en` is 0 at a clock edge, after that edge `pwr_down`, `listen_win` and `neg_start` are all 0 and the block is in full power; no negotiation request is issued.
- R2: Enabled and in full power, with `line_active` low, the cycle after the edge that samples the `IDLE_TICKS`-th `tick` sees `pwr_down` = 1 and `listen_win` = 0.
- R3: In full power, a cycle with `line_active` = 1 restarts the silence count, so `IDLE_TICKS` further ticks are needed before power-down; this holds even when a tick arrives in the same cycle.
- R4: In the sleep state, the cycle after the edge that samples the `SLEEP_TICKS`-th `tick` sees `pwr_down` = 0 and `listen_win` = 1.
- R5: In the sleep state `line_active` has no effect: `pwr_down` stays 1 and `neg_start` stays 0.
- R6: A listening window that receives `LISTEN_TICKS` ticks with `line_active` low ends with `pwr_down` = 1 and `listen_win` = 0 on the next cycle.
- R7: `line_active` = 1 during a listening window makes the next cycle show `pwr_down` = 0, `listen_win` = 0 and `neg_start` = 1; `neg_start` is 1 for exactly that one cycle.
- R8: If `line_active` = 1 arrives in the same cycle as the tick that would close the listening window, the wake-up of R7 takes priority over the return to sleep.
- R9: After reset all three outputs are 0 and the block is in full power with a cleared silence count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| saver_en | input | 1 | Enables the energy-saving behaviour |
| line_active | input | 1 | Receive line shows valid pulses or data |
| tick | input | 1 | One-cycle timebase strobe |
| pwr_down | output | 1 | Request to power down most circuits |
| listen_win | output | 1 | Short listening window is open |
| neg_start | output | 1 | One-cycle request to restart link negotiation |

## Verification
Two functions can coincide in a single cycle: closing a listening window on its last tick and waking on line activity, and likewise reloading the silence count and expiring it in full power. The bench drives activity together with the final tick in a directed case and lets random stimulus with frequent ticks produce more such overlaps. A bench model built from the requirements, where activity outranks expiry, predicts every output each cycle, and each mismatch is reported under the requirement matching the model's state and inputs.

// File: rtl/esc_pkg.sv
package esc_pkg;
  typedef enum logic [1:0] {
    ST_AWAKE  = 2'd0,
    ST_DOZE   = 2'd1,
    ST_LISTEN = 2'd2
  } esc_state_t;
endpackage

// File: rtl/esc_interval_timer.sv
module esc_interval_timer #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          tick,
  input  logic [CW-1:0] limit,
  output logic          expire
);
  logic [CW-1:0] cnt;

  assign expire = tick && (cnt == limit - CW'(1));

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
    end else if (tick) begin
      cnt <= expire ? '0 : cnt + CW'(1);
    end
  end

  // the count never reaches the active interval limit (R2, R4, R6)
  assert_cnt_below_limit_R2: assert property (@(posedge clk) disable iff (rst)
    cnt < limit);
endmodule

// File: rtl/esc_fsm.sv
module esc_fsm
  import esc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  input  logic       active,
  input  logic       expire,
  output esc_state_t state,
  output logic       clr,
  output logic       pwr_down,
  output logic       listen_win,
  output logic       neg_start
);
  esc_state_t nxt;
  logic       start_nxt;

  always_comb begin
    nxt       = state;
    start_nxt = 1'b0;
    if (!en) begin
      nxt = ST_AWAKE;
    end else begin
      unique case (state)
        ST_AWAKE: begin
          if (!active && expire) nxt = ST_DOZE;
        end
        ST_DOZE: begin
          if (expire) nxt = ST_LISTEN;
        end
        ST_LISTEN: begin
          if (active) begin
            nxt       = ST_AWAKE;
            start_nxt = 1'b1;
          end else if (expire) begin
            nxt = ST_DOZE;
          end
        end
        default: nxt = ST_AWAKE;
      endcase
    end
  end

  assign clr = !en || (nxt != state) || (state == ST_AWAKE && active);

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_AWAKE;
      pwr_down   <= 1'b0;
      listen_win <= 1'b0;
      neg_start  <= 1'b0;
    end else begin
      state      <= nxt;
      pwr_down   <= (nxt == ST_DOZE);
      listen_win <= (nxt == ST_LISTEN);
      neg_start  <= start_nxt;
    end
  end

  assert_off_full_power_R1: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!pwr_down && !listen_win && !neg_start));

  assert_doze_ignores_line_R5: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DOZE && en && !expire) |=> (pwr_down && !neg_start));

  assert_start_one_cycle_R7: assert property (@(posedge clk) disable iff (rst)
    neg_start |=> !neg_start);

  assert_start_full_power_R7: assert property (@(posedge clk) disable iff (rst)
    neg_start |-> (!pwr_down && !listen_win));

  assert_wake_wins_R8: assert property (@(posedge clk) disable iff (rst)
    (state == ST_LISTEN && en && active) |=> neg_start);

  assert_modes_exclusive_R4: assert property (@(posedge clk) disable iff (rst)
    !(pwr_down && listen_win));
endmodule

// File: rtl/energy_sleep_ctrl.sv
module energy_sleep_ctrl
  import esc_pkg::*;
#(
  parameter int IDLE_TICKS   = 5,
  parameter int SLEEP_TICKS  = 4,
  parameter int LISTEN_TICKS = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic saver_en,
  input  logic line_active,
  input  logic tick,
  output logic pwr_down,
  output logic listen_win,
  output logic neg_start
);
  localparam int MAX_A = (IDLE_TICKS > SLEEP_TICKS) ? IDLE_TICKS : SLEEP_TICKS;
  localparam int MAX_T = (MAX_A > LISTEN_TICKS) ? MAX_A : LISTEN_TICKS;
  localparam int CW    = $clog2(MAX_T + 1);

  esc_state_t    state;
  logic          clr;
  logic          expire;
  logic [CW-1:0] limit;

  always_comb begin
    unique case (state)
      ST_DOZE:   limit = CW'(SLEEP_TICKS);
      ST_LISTEN: limit = CW'(LISTEN_TICKS);
      default:   limit = CW'(IDLE_TICKS);
    endcase
  end

  esc_interval_timer #(.CW(CW)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .clr    (clr),
    .tick   (tick),
    .limit  (limit),
    .expire (expire)
  );

  esc_fsm u_fsm (
    .clk        (clk),
    .rst        (rst),
    .en         (saver_en),
    .active     (line_active),
    .expire     (expire),
    .state      (state),
    .clr        (clr),
    .pwr_down   (pwr_down),
    .listen_win (listen_win),
    .neg_start  (neg_start)
  );
endmodule

// File: tb/energy_sleep_ctrl_tb.sv
`timescale 1ns/1ps
module energy_sleep_ctrl_tb;
  localparam int IDLE   = 5;
  localparam int SLEEP  = 4;
  localparam int LISTEN = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b0, act = 1'b0, tk = 1'b0;
  logic pwr_down, listen_win, neg_start;

  int checks = 0;
  int errors = 0;

  // bench model: 0 awake, 1 doze, 2 listen
  int m_st  = 0;
  int m_cnt = 0;
  bit m_start = 1'b0;

  always #10 clk = ~clk;

  energy_sleep_ctrl #(.IDLE_TICKS(IDLE), .SLEEP_TICKS(SLEEP), .LISTEN_TICKS(LISTEN)) u_dut (
    .clk(clk), .rst(rst), .saver_en(en), .line_active(act), .tick(tk),
    .pwr_down(pwr_down), .listen_win(listen_win), .neg_start(neg_start)
  );

  function automatic string tag_of(bit e, bit a, bit t);
    if (!e) return "R1";
    case (m_st)
      0: return a ? "R3" : "R2";
      1: return a ? "R5" : "R4";
      default: begin
        if (a && t && m_cnt == LISTEN - 1) return "R8";
        return a ? "R7" : "R6";
      end
    endcase
  endfunction

  function automatic void model_step(bit e, bit a, bit t);
    m_start = 1'b0;
    if (!e) begin
      m_st = 0; m_cnt = 0;
    end else begin
      case (m_st)
        0: if (a) m_cnt = 0;
           else if (t) begin
             if (m_cnt == IDLE - 1) begin m_st = 1; m_cnt = 0; end else m_cnt++;
           end
        1: if (t) begin
             if (m_cnt == SLEEP - 1) begin m_st = 2; m_cnt = 0; end else m_cnt++;
           end
        default: if (a) begin
             m_st = 0; m_cnt = 0; m_start = 1'b1;
           end else if (t) begin
             if (m_cnt == LISTEN - 1) begin m_st = 1; m_cnt = 0; end else m_cnt++;
           end
      endcase
    end
  endfunction

  task automatic compare(string tag);
    bit ep, el;
    ep = (m_st == 1);
    el = (m_st == 2);
    checks++;
    if (pwr_down !== ep || listen_win !== el || neg_start !== m_start) begin
      errors++;
      $display("FAIL %s: got pwr_down=%b listen_win=%b neg_start=%b, expected %b %b %b",
               tag, pwr_down, listen_win, neg_start, ep, el, m_start);
    end
  endtask

  task automatic cyc(bit e, bit a, bit t);
    string tag;
    en = e; act = a; tk = t;
    tag = tag_of(e, a, t);
    @(posedge clk);
    model_step(e, a, t);
    @(negedge clk);
    compare(tag);
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      cyc(1'b1, 1'b0, 1'b1);
      cyc(1'b1, 1'b0, 1'b0);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog: got timeout, expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    compare("R9"); // reset state
    ticks(IDLE);                 // R2 enter doze
    cyc(1'b1, 1'b1, 1'b0);       // R5 activity ignored while asleep
    cyc(1'b1, 1'b1, 1'b1);       // R5 with a tick
    ticks(SLEEP - 1);            // R4 open window
    ticks(LISTEN);               // R6 silent window back to sleep
    ticks(SLEEP);                // R4
    cyc(1'b1, 1'b1, 1'b0);       // R7 wake with start pulse
    cyc(1'b1, 1'b0, 1'b0);       // R7 pulse ends
    ticks(IDLE - 1);
    cyc(1'b1, 1'b1, 1'b1);       // R3 activity with the last idle tick
    ticks(IDLE);                 // R3 full count again, R2
    ticks(SLEEP);                // R4
    ticks(LISTEN - 1);
    cyc(1'b1, 1'b1, 1'b1);       // R8 activity with the closing tick
    cyc(1'b1, 1'b0, 1'b0);
    ticks(IDLE);
    cyc(1'b0, 1'b0, 1'b1);       // R1 disable from doze
    cyc(1'b0, 1'b1, 1'b1);       // R1
    ticks(IDLE + SLEEP);
    cyc(1'b0, 1'b1, 1'b0);       // R1 disable from listen, no start
    for (int i = 0; i < 6000; i++) begin
      cyc(($urandom % 60) != 0, ($urandom % 12) == 0, ($urandom % 2) == 0);
    end
    finish_run();
  end
endmodule